// File: doc/BRIEF.md
# Longest Prefix Match Engine

This block finds the best matching route for a 32-bit destination address. Routes are kept in one small exact-match table per prefix length. A lookup does a binary search over the prefix lengths, not over the entries. Each probe compares the top bits of the address with every entry of one table in parallel. A probe that matches moves the search to the longer half of the length range. A probe that misses moves it to the shorter half.

Some entries are markers. A marker sits at a shorter length and shows that longer prefixes exist below it. Software precomputes, for each marker, the best real route that covers the marker's own bits. When every longer probe then misses, that stored result is the answer, so the search never backtracks.

Tables are loaded through a simple write port, one slot at a time. A lookup is accepted only while the engine is idle. It returns one response pulse carrying a hit flag, the matched prefix length and a 12-bit next-hop index. With the default parameters there are eight lengths, 4, 8, 12 and so on up to 32, and eight slots per length.

Top module: `lpm_engine`

## Requirements
- R1: While reset is held and after it is released, `busy` and `rsp_valid` are low.
- R2: A request (`req_valid` high while `busy` is low) is accepted on that clock edge. `busy` is high from the following cycle until the response edge.
- R3: A request presented while `busy` is high is ignored. It produces no extra response and does not change the result of the lookup in flight.
- R4: `rsp_valid` is a single-cycle pulse.
  - It rises no later than the MAXP-th clock edge after the accepting edge, where MAXP = ceil(log2(NUM_LEN)) + 1.
  - `busy` falls on the same edge.
- R5: Table i holds prefixes of length (i+1)*LEN_STEP.
  - An entry matches when its valid bit is set and its top (i+1)*LEN_STEP bits equal those of the address.
  - Address bits below that length have no effect.
- R6: The first probe is at table index floor((NUM_LEN-1)/2), within the half-open index range [0, NUM_LEN). A matching probe continues in the indexes above the probed one. A missing probe continues in the indexes below it. The search ends when the range is empty.
- R7: A matching entry with its real-prefix flag set records its own length and its next hop. Given correctly placed markers, the response is the longest real prefix covering the address.
- R8: A matching entry that is a marker only, with its stored-best valid bit set, records its stored length and its next-hop field. That result is returned when all later, longer probes miss.
- R9: When nothing was recorded along the search path, the response has `rsp_hit` low, `rsp_len` 0 and `rsp_nh` 0. A marker-only entry whose stored-best valid bit is low records nothing.
- R10: A write replaces the whole entry in the addressed table and slot. Writing valid low removes the entry from later lookups.
- R11: An entry with both the real-prefix flag and the marker flag set reports its own length, not its stored-best length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Destination address to look up |
| busy | output | 1 | Search in progress; requests are refused |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | A route was found |
| rsp_len | output | 6 | Matched prefix length (0 on a miss) |
| rsp_nh | output | 12 | Next-hop index (0 on a miss) |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 3 | Table index, i.e. prefix length index |
| wr_slot | input | 3 | Slot within the table |
| wr_valid | input | 1 | Entry valid |
| wr_marker | input | 1 | Entry is a marker |
| wr_real | input | 1 | Entry is a real prefix |
| wr_prefix | input | 32 | Prefix bits, left aligned |
| wr_nh | input | 12 | Next hop of the prefix, or of the marker's stored best route |
| wr_bm_valid | input | 1 | Marker's stored best route exists |
| wr_bm_len | input | 6 | Length of the marker's stored best route |

## Verification
The bench targets four failure modes:
- Misses that fall back on a marker's stored result, where an engine that ignored the stored result would wrongly report no route.
- Markers that carry no stored result, where an engine that took the marker as a route would report a false hit.
- Entries that are both a real prefix and a marker, where the wrong field choice would report a shorter length.
- A request hammered in while the engine is busy, which a faulty guard would turn into a second response or a corrupted address.

Random route sets drawn around a few base addresses are programmed together with correct markers. Each lookup is checked against a brute-force longest match over the real routes. Any error in probe order, the half-range update or masking shows up as a different length or next hop.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int NH_W   = 12;
  localparam int LEN_W  = 6;

  typedef struct packed {
    logic              valid;
    logic              marker;
    logic              real_pfx;
    logic [ADDR_W-1:0] prefix;
    logic [NH_W-1:0]   nh;
    logic              bm_valid;
    logic [LEN_W-1:0]  bm_len;
  } lpm_entry_t;

  typedef enum logic {S_IDLE, S_SRCH} lpm_state_e;

  // Left-aligned mask covering the top len bits.
  function automatic logic [ADDR_W-1:0] pfx_mask(input logic [LEN_W-1:0] len);
    logic [ADDR_W-1:0] m;
    if (len == '0) m = '0;
    else           m = {ADDR_W{1'b1}} << (ADDR_W - int'(len));
    return m;
  endfunction
endpackage

// File: rtl/lpm_len_table.sv
module lpm_len_table
  import lpm_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PLEN  = 8,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  lpm_entry_t        wr_data,
  input  logic [ADDR_W-1:0] key,
  output logic              hit,
  output lpm_entry_t        hit_entry
);
  localparam logic [ADDR_W-1:0] MASK = pfx_mask(LEN_W'(PLEN));

  lpm_entry_t ent [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    lpm_entry_t slot_q;
    logic       slot_en;
    assign slot_en = wr_en && (wr_slot == SLOT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wr_data;
    end
    assign ent[s] = slot_q;
  end

  // Lowest matching slot wins.
  always_comb begin
    hit       = 1'b0;
    hit_entry = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (ent[s].valid && (((ent[s].prefix ^ key) & MASK) == '0)) begin
        hit       = 1'b1;
        hit_entry = ent[s];
      end
    end
  end
endmodule

// File: rtl/lpm_search_ctrl.sv
module lpm_search_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_LEN  = 8,
  parameter int LEN_STEP = 4,
  localparam int TIDX_W = (NUM_LEN > 1) ? $clog2(NUM_LEN) : 1,
  localparam int CNT_W  = $clog2(NUM_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic [TIDX_W-1:0] probe_idx,
  output logic [ADDR_W-1:0] key,
  input  logic              probe_hit,
  input  lpm_entry_t        probe_entry,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [NH_W-1:0]   rsp_nh
);
  lpm_state_e        st_q, st_n;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  lo_q, lo_n, hi_q, hi_n;
  logic              bh_q, bh_n;
  logic [LEN_W-1:0]  bl_q, bl_n;
  logic [NH_W-1:0]   bn_q, bn_n;
  logic              rv_q, rv_n;
  logic              rh_q;
  logic [LEN_W-1:0]  rl_q;
  logic [NH_W-1:0]   rn_q;
  logic              addr_en, rsp_en;
  logic [CNT_W:0]    mid_w;
  logic [CNT_W-1:0]  mid;
  logic [LEN_W-1:0]  probe_len;
  logic              unused_fields;

  assign unused_fields = ^{probe_entry.prefix, probe_entry.valid};

  assign mid_w     = ({1'b0, lo_q} + {1'b0, hi_q} - 1'b1) >> 1;
  assign mid       = mid_w[CNT_W-1:0];
  assign probe_idx = TIDX_W'(mid);
  assign probe_len = LEN_W'((32'(mid) + 32'd1) * 32'(LEN_STEP));
  assign key       = addr_q;

  always_comb begin
    st_n    = st_q;
    lo_n    = lo_q;
    hi_n    = hi_q;
    bh_n    = bh_q;
    bl_n    = bl_q;
    bn_n    = bn_q;
    rv_n    = 1'b0;
    addr_en = 1'b0;
    rsp_en  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          st_n    = S_SRCH;
          addr_en = 1'b1;
          lo_n    = '0;
          hi_n    = CNT_W'(NUM_LEN);
          bh_n    = 1'b0;
          bl_n    = '0;
          bn_n    = '0;
        end
      end
      S_SRCH: begin
        if (probe_hit) begin
          if (probe_entry.real_pfx) begin
            bh_n = 1'b1;
            bl_n = probe_len;
            bn_n = probe_entry.nh;
          end else if (probe_entry.marker && probe_entry.bm_valid) begin
            bh_n = 1'b1;
            bl_n = probe_entry.bm_len;
            bn_n = probe_entry.nh;
          end
          lo_n = mid + 1'b1;
        end else begin
          hi_n = mid;
        end
        if (lo_n >= hi_n) begin
          st_n   = S_IDLE;
          rv_n   = 1'b1;
          rsp_en = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      lo_q <= '0;
      hi_q <= CNT_W'(NUM_LEN);
      bh_q <= 1'b0;
      bl_q <= '0;
      bn_q <= '0;
      rv_q <= 1'b0;
    end else begin
      st_q <= st_n;
      lo_q <= lo_n;
      hi_q <= hi_n;
      bh_q <= bh_n;
      bl_q <= bl_n;
      bn_q <= bn_n;
      rv_q <= rv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_q <= 1'b0;
      rl_q <= '0;
      rn_q <= '0;
    end else if (rsp_en) begin
      rh_q <= bh_n;
      rl_q <= bl_n;
      rn_q <= bn_n;
    end
  end

  assign busy      = (st_q == S_SRCH);
  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_len   = rl_q;
  assign rsp_nh    = rn_q;
endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
  import lpm_pkg::*;
#(
  parameter int NUM_LEN  = 8,
  parameter int LEN_STEP = 4,
  parameter int DEPTH    = 8,
  localparam int TIDX_W = (NUM_LEN > 1) ? $clog2(NUM_LEN) : 1,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [5:0]        rsp_len,
  output logic [11:0]       rsp_nh,
  input  logic              wr_en,
  input  logic [TIDX_W-1:0] wr_tbl,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic              wr_marker,
  input  logic              wr_real,
  input  logic [31:0]       wr_prefix,
  input  logic [11:0]       wr_nh,
  input  logic              wr_bm_valid,
  input  logic [5:0]        wr_bm_len
);
  lpm_entry_t        wr_data;
  logic [NUM_LEN-1:0] hit_vec;
  lpm_entry_t        ent_vec [NUM_LEN];
  logic [TIDX_W-1:0] probe_idx;
  logic [ADDR_W-1:0] key;
  logic              probe_hit;
  lpm_entry_t        probe_entry;

  assign wr_data = '{valid: wr_valid, marker: wr_marker, real_pfx: wr_real,
                     prefix: wr_prefix, nh: wr_nh, bm_valid: wr_bm_valid,
                     bm_len: wr_bm_len};

  for (genvar i = 0; i < NUM_LEN; i++) begin : g_tbl
    logic tbl_wr;
    assign tbl_wr = wr_en && (wr_tbl == TIDX_W'(i));
    lpm_len_table #(.DEPTH(DEPTH), .PLEN((i + 1) * LEN_STEP)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr),
      .wr_slot  (wr_slot),
      .wr_data  (wr_data),
      .key      (key),
      .hit      (hit_vec[i]),
      .hit_entry(ent_vec[i])
    );
  end

  always_comb begin
    probe_hit   = 1'b0;
    probe_entry = '0;
    for (int i = 0; i < NUM_LEN; i++) begin
      if (probe_idx == TIDX_W'(i)) begin
        probe_hit   = hit_vec[i];
        probe_entry = ent_vec[i];
      end
    end
  end

  lpm_search_ctrl #(.NUM_LEN(NUM_LEN), .LEN_STEP(LEN_STEP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .busy       (busy),
    .probe_idx  (probe_idx),
    .key        (key),
    .probe_hit  (probe_hit),
    .probe_entry(probe_entry),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_len    (rsp_len),
    .rsp_nh     (rsp_nh)
  );
endmodule

// File: rtl/lpm_engine_chk.sv
module lpm_engine_chk #(
  parameter int NUM_LEN = 8,
  localparam int MAXP = $clog2(NUM_LEN) + 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [5:0]  rsp_len,
  input logic [11:0] rsp_nh
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busy_cnt <= '0;
    else if (req_valid && !busy)    busy_cnt <= 8'd1;
    else if (busy)                  busy_cnt <= busy_cnt + 8'd1;
  end

  // R2: an accepted request makes the engine busy next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R4: search bounded by MAXP probe cycles
  a_r4_probe_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt <= 8'(MAXP)));

  // R4: response strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4: response ends a busy period
  a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));

  // R9: a miss carries zero length and next hop
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_len == 6'd0 && rsp_nh == 12'd0));

  // R7: reported length never exceeds the address width
  a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_len <= 6'd32));
endmodule

bind lpm_engine lpm_engine_chk #(.NUM_LEN(NUM_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_len  (rsp_len),
  .rsp_nh   (rsp_nh)
);

// File: tb/lpm_engine_bench.sv
`timescale 1ns/1ps
module lpm_engine_bench;
  localparam int NL = 8, D = 8, STEP = 4, MAXP = 4, MAXR = 4;

  logic        clk, rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        busy, rsp_valid, rsp_hit;
  logic [5:0]  rsp_len;
  logic [11:0] rsp_nh;
  logic        wr_en, wr_valid, wr_marker, wr_real, wr_bm_valid;
  logic [2:0]  wr_tbl, wr_slot;
  logic [31:0] wr_prefix;
  logic [11:0] wr_nh;
  logic [5:0]  wr_bm_len;

  lpm_engine u_lpm_engine (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got cycle %0d, expected end before 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // shadow of what the bench programs, plus the route list
  bit          sv [NL][D];
  bit          sm [NL][D];
  bit          sr [NL][D];
  logic [31:0] sp [NL][D];
  logic [11:0] sn [NL][D];
  bit          sbv[NL][D];
  logic [5:0]  sbl[NL][D];
  int          rc;
  int          rj [MAXR];
  logic [31:0] rp [MAXR];
  logic [11:0] rn [MAXR];

  function automatic logic [31:0] msk(input int len);
    return (len == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len));
  endfunction

  function automatic int plen(input int j);
    return (j + 1) * STEP;
  endfunction

  function automatic void brute(input logic [31:0] a, input int maxlen,
                                output bit f, output int l, output logic [11:0] nh);
    f = 0; l = 0; nh = 0;
    for (int r = 0; r < rc; r++) begin
      int len = plen(rj[r]);
      if (len <= maxlen && ((a ^ rp[r]) & msk(len)) == 0 && (!f || len > l)) begin
        f = 1; l = len; nh = rn[r];
      end
    end
  endfunction

  function automatic void sh_clear();
    for (int j = 0; j < NL; j++)
      for (int s = 0; s < D; s++) begin
        sv[j][s] = 0; sm[j][s] = 0; sr[j][s] = 0; sp[j][s] = 0;
        sn[j][s] = 0; sbv[j][s] = 0; sbl[j][s] = 0;
      end
  endfunction

  function automatic void sh_insert(input int j, input logic [31:0] p,
                                    input bit is_pfx, input logic [11:0] nh);
    logic [31:0] pm = p & msk(plen(j));
    for (int s = 0; s < D; s++)
      if (sv[j][s] && sp[j][s] == pm) begin
        if (is_pfx) begin sr[j][s] = 1; sn[j][s] = nh; end
        else sm[j][s] = 1;
        return;
      end
    for (int s = 0; s < D; s++)
      if (!sv[j][s]) begin
        sv[j][s] = 1; sp[j][s] = pm; sm[j][s] = !is_pfx; sr[j][s] = is_pfx;
        sn[j][s] = is_pfx ? nh : 12'h0;
        return;
      end
  endfunction

  // software role: place markers along each route's search path, fill their best match
  function automatic void sh_build();
    sh_clear();
    for (int r = 0; r < rc; r++) sh_insert(rj[r], rp[r], 1, rn[r]);
    for (int r = 0; r < rc; r++) begin
      int lo = 0, hi = NL;
      while (lo < hi) begin
        int mid = (lo + hi - 1) / 2;
        if (mid == rj[r]) break;
        if (mid < rj[r]) begin sh_insert(mid, rp[r], 0, 0); lo = mid + 1; end
        else hi = mid;
      end
    end
    for (int j = 0; j < NL; j++)
      for (int s = 0; s < D; s++)
        if (sv[j][s]) begin
          if (sr[j][s]) begin sbv[j][s] = 1; sbl[j][s] = 6'(plen(j)); end
          else if (sm[j][s]) begin
            bit f; int l; logic [11:0] nh;
            brute(sp[j][s], plen(j), f, l, nh);
            sbv[j][s] = f; sbl[j][s] = 6'(l); sn[j][s] = nh;
          end
        end
  endfunction

  task automatic prog_all();
    for (int j = 0; j < NL; j++)
      for (int s = 0; s < D; s++) begin
        @(negedge clk);
        wr_en = 1; wr_tbl = 3'(j); wr_slot = 3'(s);
        wr_valid = sv[j][s]; wr_marker = sm[j][s]; wr_real = sr[j][s];
        wr_prefix = sp[j][s]; wr_nh = sn[j][s];
        wr_bm_valid = sbv[j][s]; wr_bm_len = sbl[j][s];
      end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input bit hammer,
                        output bit got, output bit h, output int l,
                        output logic [11:0] nh, output int edges);
    int n;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    n = 1;
    chk(busy === 1'b1, "R2", $sformatf("busy after accept got %b expected 1", busy));
    while (!rsp_valid && n < 20) begin
      if (hammer && n == 1) begin req_valid = 1; req_addr = ~a; end
      @(negedge clk);
      n++;
      if (hammer && n == 3) req_valid = 0;
    end
    req_valid = 0;
    got = rsp_valid; h = rsp_hit; l = int'(rsp_len); nh = rsp_nh; edges = n - 1;
    chk(got && edges <= MAXP, "R4",
        $sformatf("response edges got %0d (valid %b) expected <= %0d", edges, got, MAXP));
  endtask

  task automatic expect_lookup(input logic [31:0] a, input bit eh, input int el,
                               input logic [11:0] en, input string tag);
    bit got, h; int l, e; logic [11:0] nh;
    lookup(a, 0, got, h, l, nh, e);
    chk(got && h == eh && l == el && nh == en, tag,
        $sformatf("addr %h got hit %b len %0d nh %h expected hit %b len %0d nh %h",
                  a, h, l, nh, eh, el, en));
  endtask

  initial begin
    logic [31:0] base [4];
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; req_addr = 0; wr_en = 0; wr_tbl = 0; wr_slot = 0;
    wr_valid = 0; wr_marker = 0; wr_real = 0; wr_prefix = 0; wr_nh = 0;
    wr_bm_valid = 0; wr_bm_len = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && rsp_valid === 1'b0, "R1",
        $sformatf("in reset busy %b rsp_valid %b expected 0 0", busy, rsp_valid));
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && rsp_valid === 1'b0, "R1",
        $sformatf("after reset busy %b rsp_valid %b expected 0 0", busy, rsp_valid));

    // empty tables: miss
    expect_lookup(32'h1234_5678, 0, 0, 12'h0, "R9");

    // directed: /8 and /28 sharing top bits
    rc = 2;
    rj[0] = 1; rp[0] = 32'h0A00_0000; rn[0] = 12'h111;
    rj[1] = 6; rp[1] = 32'h0A0B_0C10; rn[1] = 12'h222;
    sh_build(); prog_all();
    expect_lookup(32'h0A0B_0C1F, 1, 28, 12'h222, "R7");
    expect_lookup(32'h0A0B_0C1A, 1, 28, 12'h222, "R5");
    expect_lookup(32'h0A0B_0C2F, 1, 8, 12'h111, "R8");
    expect_lookup(32'h0AFF_0000, 1, 8, 12'h111, "R6");

    // remove the /8: marker keeps no best match, so miss
    rc = 1; rj[0] = 6; rp[0] = 32'h0A0B_0C10; rn[0] = 12'h222;
    sh_build(); prog_all();
    expect_lookup(32'h0A0B_0C2F, 0, 0, 12'h0, "R10");
    expect_lookup(32'h0A0B_0C2F, 0, 0, 12'h0, "R9");
    expect_lookup(32'h0A0B_0C15, 1, 28, 12'h222, "R10");

    // entry that is both real and marker with a shorter stored best
    sh_clear();
    sv[3][0] = 1; sr[3][0] = 1; sm[3][0] = 1; sp[3][0] = 32'h0A0B_0000;
    sn[3][0] = 12'h333; sbv[3][0] = 1; sbl[3][0] = 6'd8;
    prog_all();
    expect_lookup(32'h0A0B_9999, 1, 16, 12'h333, "R11");

    // busy refusal
    begin
      bit got, h; int l, e; logic [11:0] nh; bit extra = 0;
      lookup(32'h0A0B_1234, 1, got, h, l, nh, e);
      chk(got && h && l == 16 && nh == 12'h333, "R3",
          $sformatf("hammered lookup got hit %b len %0d nh %h expected 1 16 333", h, l, nh));
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (rsp_valid || busy) extra = 1;
      end
      chk(!extra, "R3", $sformatf("extra activity after refused request got %b expected 0", extra));
    end

    // random route sets
    for (int sc = 0; sc < 30; sc++) begin
      for (int b = 0; b < 4; b++) base[b] = $urandom;
      rc = 0;
      for (int t = 0; t < MAXR; t++) begin
        int j = $urandom_range(NL - 1);
        logic [31:0] p = base[$urandom_range(3)] & msk(plen(j));
        bit dup = 0;
        for (int r = 0; r < rc; r++) if (rj[r] == j && rp[r] == p) dup = 1;
        if (!dup) begin
          rj[rc] = j; rp[rc] = p; rn[rc] = 12'($urandom_range(4095, 1)); rc++;
        end
      end
      sh_build(); prog_all();
      for (int q = 0; q < 16; q++) begin
        logic [31:0] a;
        bit f; int l; logic [11:0] nh;
        if (q % 5 == 4) a = $urandom;
        else a = base[$urandom_range(3)] ^ (($urandom_range(1) != 0) ? (32'h1 << $urandom_range(31)) : 32'h0);
        brute(a, 32, f, l, nh);
        expect_lookup(a, f, l, nh, "R7");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule